// File: doc/BRIEF.md
# Indirect PCM Channel Register Interface

This block is the host-facing register slave of an eight-voice sample playback unit. A byte-wide bus reaches the per-voice parameters through a channel pointer: the host first picks a voice through the control register, then writes that voice's volume envelope, stereo pan, 16-bit pitch step, 16-bit loop point and 8-bit start page through a small set of fixed offsets. The same control register can instead choose which 4 KB page of the 64 KB sample store appears in the upper half of the bus address space. A global run flag is also kept here.

A separate voice-gate register switches voices on and off with inverted polarity. Every voice that is switched off has its running playback position rewound to its start page. The playback engine (outside this block) reads each voice's parameters through a combinational view port and writes back the advancing position. The host can read that live position a byte at a time. The sample store itself is an external RAM. This block drives its address, write strobe and write data, and returns its read data on the bus.

Top module: `pcm_chan_regif`

## Requirements
- R1: After reset every voice has pan 0xFF and all other voice fields zero, `chan_on` is 0, `glob_en` is 0, the selected voice and page are 0, and `bus_rdata` is 0x00.
- R2: A bus write (`bus_sel`=1, `bus_we`=1) at offset 0x00, 0x01, 0x02, 0x03, 0x04 or 0x05 sets, in the selected voice only, envelope, pan, step[7:0], step[15:8], loop[7:0] or loop[15:8] respectively, visible from the clock edge that samples the write.
- R3: A write at offset 0x06 stores the byte as the start page. When the selected voice's `chan_on` bit is 0, its position becomes the byte shifted left by 19. When that bit is 1, the position is left unchanged.
- R4: A write at offset 0x07 always sets `glob_en` to data bit 7. If data bit 6 is 1, data bits 2:0 become the selected voice and the page is unchanged. If bit 6 is 0, data bits 3:0 become the page and the voice is unchanged.
- R5: A write at offset 0x08 sets `chan_on` to the inverse of the data byte. Each voice whose data bit is 1 has its position reloaded from its stored start page shifted left by 19.
- R6: Bus addresses with bit 12 set reach the sample store at `mem_addr` = page*4096 + address[11:0]. Writes pulse `mem_we` in the same cycle. A read returns `mem_rdata` in `bus_rdata` after the next clock edge.
- R7: A read at 0x10 to 0x1F returns position bits 18:11 (even address) or 26:19 (odd address) of voice (address>>1)&7, as they were before that edge.
- R8: Reads anywhere else below 0x1000 return 0xFF. Writes at offsets 0x09 to 0x0FFF change no state. Cycles without a read leave `bus_rdata` unchanged.
- R9: An engine update (`eng_upd_valid`) sets the position of voice `eng_upd_ch`. If a bus reload from R3 or R5 targets that voice in the same cycle, the reload wins.
- R10: The `eng_*` outputs show the stored fields of voice `eng_ch` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address, bit 12 selects the sample window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mem_we | output | 1 | Sample store write strobe |
| mem_addr | output | 16 | Sample store byte address |
| mem_wdata | output | 8 | Sample store write data |
| mem_rdata | input | 8 | Sample store read data, combinational |
| eng_ch | input | 3 | Voice shown on the engine view |
| eng_upd_valid | input | 1 | Engine position write strobe |
| eng_upd_ch | input | 3 | Voice whose position the engine writes |
| eng_upd_pos | input | 27 | New position, 16.11 fixed point |
| eng_env | output | 8 | Envelope of voice `eng_ch` |
| eng_pan | output | 8 | Pan of voice `eng_ch` |
| eng_step | output | 16 | Pitch step of voice `eng_ch` |
| eng_loop | output | 16 | Loop point of voice `eng_ch` |
| eng_start | output | 8 | Start page of voice `eng_ch` |
| eng_pos | output | 27 | Position of voice `eng_ch` |
| chan_on | output | 8 | Voice gate, 1 = running |
| glob_en | output | 1 | Global run flag |

## Verification
The bench goes after the cases where a pointer or mode bit is easy to misroute. A control write with bit 6 clear must move the page and leave the voice pointer alone; a design that updated both would send later field writes to voice 0-7 by page number. A start-page write to a running voice must not rewind it, and a gate write must rewind using the old start page, not stale or freshly written data. A same-cycle engine update and gate reload of one voice is driven, where a design with the wrong priority would let playback escape the rewind. Reads at odd/even pointer offsets and page boundaries catch a swapped byte half or an address built from the wrong page bits.

// File: rtl/pcm_reg_pkg.sv
package pcm_reg_pkg;

    localparam int NUM_CH   = 8;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int DW       = 8;
    localparam int BANK_W   = 4;
    localparam int WIN_AW   = 12;
    localparam int BUS_AW   = WIN_AW + 1;
    localparam int MEM_AW   = BANK_W + WIN_AW;
    localparam int FRAC_W   = 11;
    localparam int START_SH = FRAC_W + DW;
    localparam int POS_W    = START_SH + DW;
    localparam int STEP_W   = 2 * DW;

    localparam logic [DW-1:0] PAN_RST   = 8'hFF;
    localparam logic [DW-1:0] RD_EMPTY  = 8'hFF;
    localparam int            EN_BIT    = 7;
    localparam int            CHSEL_BIT = 6;

    typedef enum logic [3:0] {
        K_ENV, K_PAN, K_STEP_LO, K_STEP_HI, K_LOOP_LO, K_LOOP_HI,
        K_START, K_CTRL, K_ONOFF, K_MEM, K_PTR, K_NONE
    } acc_kind_e;

    typedef struct packed {
        logic [DW-1:0]     env;
        logic [DW-1:0]     pan;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] loop_pt;
        logic [DW-1:0]     start;
        logic [POS_W-1:0]  pos;
    } chan_slot_t;

    function automatic acc_kind_e decode_addr(input logic [BUS_AW-1:0] a);
        acc_kind_e k;
        if (a[BUS_AW-1])
            k = K_MEM;
        else if (a[BUS_AW-2:4] == 8'h01)
            k = K_PTR;
        else if (a[BUS_AW-2:4] != '0)
            k = K_NONE;
        else begin
            case (a[3:0])
                4'h0:    k = K_ENV;
                4'h1:    k = K_PAN;
                4'h2:    k = K_STEP_LO;
                4'h3:    k = K_STEP_HI;
                4'h4:    k = K_LOOP_LO;
                4'h5:    k = K_LOOP_HI;
                4'h6:    k = K_START;
                4'h7:    k = K_CTRL;
                4'h8:    k = K_ONOFF;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [POS_W-1:0] page_to_pos(input logic [DW-1:0] s);
        return {s, {START_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/pcm_ctrl_regs.sv
module pcm_ctrl_regs
    import pcm_reg_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CH_W,
    parameter int B_W  = BANK_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  acc_kind_e       kind,
    input  logic [DW-1:0]   wdata,
    output logic [C_W-1:0]  sel_ch,
    output logic [B_W-1:0]  bank,
    output logic            glob_en,
    output logic [N_CH-1:0] chan_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_ch  <= '0;
            bank    <= '0;
            glob_en <= 1'b0;
            chan_on <= '0;
        end else if (wr_en) begin
            case (kind)
                K_CTRL: begin
                    glob_en <= wdata[EN_BIT];
                    if (wdata[CHSEL_BIT])
                        sel_ch <= wdata[C_W-1:0];
                    else
                        bank <= wdata[B_W-1:0];
                end
                K_ONOFF: chan_on <= ~wdata[N_CH-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcm_chan_bank.sv
module pcm_chan_bank
    import pcm_reg_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  acc_kind_e        kind,
    input  logic [DW-1:0]    wdata,
    input  logic [C_W-1:0]   sel_ch,
    input  logic [N_CH-1:0]  chan_on,
    input  logic             upd_valid,
    input  logic [C_W-1:0]   upd_ch,
    input  logic [POS_W-1:0] upd_pos,
    output chan_slot_t       slots [N_CH]
);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        chan_slot_t cur;
        chan_slot_t nxt;
        logic       hit;
        logic       gate_rewind;

        always_comb begin
            hit         = wr_en && (sel_ch == C_W'(g));
            gate_rewind = wr_en && (kind == K_ONOFF) && wdata[g];
            nxt         = cur;
            // engine position first, bus reloads below override it
            if (upd_valid && (upd_ch == C_W'(g)))
                nxt.pos = upd_pos;
            if (hit) begin
                case (kind)
                    K_ENV:     nxt.env                 = wdata;
                    K_PAN:     nxt.pan                 = wdata;
                    K_STEP_LO: nxt.step[DW-1:0]        = wdata;
                    K_STEP_HI: nxt.step[STEP_W-1:DW]   = wdata;
                    K_LOOP_LO: nxt.loop_pt[DW-1:0]     = wdata;
                    K_LOOP_HI: nxt.loop_pt[STEP_W-1:DW] = wdata;
                    K_START: begin
                        nxt.start = wdata;
                        if (!chan_on[g])
                            nxt.pos = page_to_pos(wdata);
                    end
                    default: ;
                endcase
            end
            if (gate_rewind)
                nxt.pos = page_to_pos(cur.start);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cur     <= '0;
                cur.pan <= PAN_RST;
            end else begin
                cur <= nxt;
            end
        end

        assign slots[g] = cur;
    end

endmodule

// File: rtl/pcm_bus_read.sv
module pcm_bus_read
    import pcm_reg_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  acc_kind_e        kind,
    input  logic [C_W:0]     lo_bits,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [POS_W-1:0] pos_arr [N_CH],
    output logic [DW-1:0]    rdata
);

    logic [POS_W-1:0] pick;
    logic [DW-1:0]    rnext;

    always_comb begin
        pick = pos_arr[lo_bits[C_W:1]];
        case (kind)
            K_MEM:   rnext = mem_rdata;
            K_PTR:   rnext = lo_bits[0] ? pick[POS_W-1:START_SH]
                                        : pick[START_SH-1:FRAC_W];
            default: rnext = RD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rnext;
    end

endmodule

// File: rtl/pcm_chan_regif.sv
module pcm_chan_regif
    import pcm_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic              eng_upd_valid,
    input  logic [CH_W-1:0]   eng_upd_ch,
    input  logic [POS_W-1:0]  eng_upd_pos,
    output logic [DW-1:0]     eng_env,
    output logic [DW-1:0]     eng_pan,
    output logic [STEP_W-1:0] eng_step,
    output logic [STEP_W-1:0] eng_loop,
    output logic [DW-1:0]     eng_start,
    output logic [POS_W-1:0]  eng_pos,
    output logic [NUM_CH-1:0] chan_on,
    output logic              glob_en
);

    acc_kind_e        kind;
    logic             wr_en;
    logic             rd_en;
    logic [CH_W-1:0]  sel_ch;
    logic [BANK_W-1:0] bank;
    chan_slot_t       slots   [NUM_CH];
    logic [POS_W-1:0] pos_arr [NUM_CH];
    chan_slot_t       view;

    assign kind  = decode_addr(bus_addr);
    assign wr_en = bus_sel && bus_we;
    assign rd_en = bus_sel && !bus_we;

    pcm_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .kind    (kind),
        .wdata   (bus_wdata),
        .sel_ch  (sel_ch),
        .bank    (bank),
        .glob_en (glob_en),
        .chan_on (chan_on)
    );

    pcm_chan_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .kind      (kind),
        .wdata     (bus_wdata),
        .sel_ch    (sel_ch),
        .chan_on   (chan_on),
        .upd_valid (eng_upd_valid),
        .upd_ch    (eng_upd_ch),
        .upd_pos   (eng_upd_pos),
        .slots     (slots)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pos
        assign pos_arr[g] = slots[g].pos;
    end

    pcm_bus_read u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .kind      (kind),
        .lo_bits   (bus_addr[CH_W:0]),
        .mem_rdata (mem_rdata),
        .pos_arr   (pos_arr),
        .rdata     (bus_rdata)
    );

    assign mem_addr  = {bank, bus_addr[WIN_AW-1:0]};
    assign mem_we    = wr_en && (kind == K_MEM);
    assign mem_wdata = bus_wdata;

    assign view      = slots[eng_ch];
    assign eng_env   = view.env;
    assign eng_pan   = view.pan;
    assign eng_step  = view.step;
    assign eng_loop  = view.loop_pt;
    assign eng_start = view.start;
    assign eng_pos   = view.pos;

endmodule

// File: rtl/pcm_chan_regif_chk.sv
module pcm_chan_regif_chk
    import pcm_reg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [DW-1:0]     mem_rdata,
    input logic [NUM_CH-1:0] chan_on,
    input logic              glob_en
);

    logic rd_acc, wr_ctrl, wr_gate, rd_win, rd_bad, page_move;

    assign rd_acc    = bus_sel && !bus_we;
    assign wr_ctrl   = bus_sel && bus_we && (bus_addr == BUS_AW'(7));
    assign wr_gate   = bus_sel && bus_we && (bus_addr == BUS_AW'(8));
    assign rd_win    = rd_acc && bus_addr[BUS_AW-1];
    assign rd_bad    = rd_acc && !bus_addr[BUS_AW-1] && (bus_addr[BUS_AW-2:4] != 8'h01);
    assign page_move = wr_ctrl && !bus_wdata[CHSEL_BIT];

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (chan_on == '0 && !glob_en && bus_rdata == '0));

    // R4
    run_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> glob_en == $past(bus_wdata[EN_BIT]));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !page_move |=> $stable(mem_addr[MEM_AW-1:WIN_AW]));

    // R5
    gate_inv_chk: assert property (@(posedge clk) disable iff (rst)
        wr_gate |=> chan_on == ~$past(bus_wdata));

    // R6
    win_we_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (bus_sel && bus_we && bus_addr[BUS_AW-1]));

    // R6
    win_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr[BUS_AW-1]) |-> mem_addr[WIN_AW-1:0] == bus_addr[WIN_AW-1:0]);

    // R6
    win_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_win |=> bus_rdata == $past(mem_rdata));

    // R8
    empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_bad |=> bus_rdata == RD_EMPTY);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> $stable(bus_rdata));

endmodule

bind pcm_chan_regif pcm_chan_regif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .chan_on   (chan_on),
    .glob_en   (glob_en)
);

// File: tb/pcm_chan_regif_test.sv
module pcm_chan_regif_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  eng_ch = '0;
    logic        eng_upd_valid = 1'b0;
    logic [2:0]  eng_upd_ch = '0;
    logic [26:0] eng_upd_pos = '0;
    logic [7:0]  eng_env, eng_pan, eng_start;
    logic [15:0] eng_step, eng_loop;
    logic [26:0] eng_pos;
    logic [7:0]  chan_on;
    logic        glob_en;

    pcm_chan_regif uut (.*);

    always #4 clk = ~clk;

    // reference model
    int      m_env [8], m_pan [8], m_step [8], m_loop [8], m_start [8];
    longint  m_pos [8];
    int      m_idx, m_bank, m_en, m_on, m_rdata;
    string   m_rtag = "R1";
    string   nxt_tag = "R8";
    bit [7:0] exp_mem [int];
    bit [7:0] phys_mem [int];
    int      total = 0, bad = 0;
    bit      finished = 0;

    localparam longint PMASK = (64'd1 << 27) - 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int a, d, ch;
        a = int'(bus_addr); d = int'(bus_wdata);
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_env[i] = 0; m_pan[i] = 8'hFF; m_step[i] = 0; m_loop[i] = 0;
                m_start[i] = 0; m_pos[i] = 0;
            end
            m_idx = 0; m_bank = 0; m_en = 0; m_on = 0; m_rdata = 0; m_rtag = "R1";
            return;
        end
        if (bus_sel && !bus_we) begin
            m_rtag = nxt_tag;
            if (a >= 'h1000)
                m_rdata = exp_mem.exists(m_bank * 4096 + (a & 'hFFF)) ?
                          int'(exp_mem[m_bank * 4096 + (a & 'hFFF)]) : 0;
            else if (a >= 'h10 && a < 'h20) begin
                ch = (a >> 1) & 7;
                m_rdata = (a & 1) ? int'((m_pos[ch] >> 19) & 'hFF) : int'((m_pos[ch] >> 11) & 'hFF);
            end else
                m_rdata = 'hFF;
        end
        if (eng_upd_valid) m_pos[eng_upd_ch] = longint'(eng_upd_pos);
        if (bus_sel && bus_we) begin
            if (a >= 'h1000) exp_mem[m_bank * 4096 + (a & 'hFFF)] = bus_wdata;
            else case (a)
                0: m_env[m_idx] = d;
                1: m_pan[m_idx] = d;
                2: m_step[m_idx] = (m_step[m_idx] & 'hFF00) | d;
                3: m_step[m_idx] = (m_step[m_idx] & 'h00FF) | (d << 8);
                4: m_loop[m_idx] = (m_loop[m_idx] & 'hFF00) | d;
                5: m_loop[m_idx] = (m_loop[m_idx] & 'h00FF) | (d << 8);
                6: begin
                    m_start[m_idx] = d;
                    if (((m_on >> m_idx) & 1) == 0) m_pos[m_idx] = longint'(d) << 19;
                end
                7: begin
                    m_en = (d >> 7) & 1;
                    if (d & 'h40) m_idx = d & 7; else m_bank = d & 'hF;
                end
                8: begin
                    for (int i = 0; i < 8; i++)
                        if ((d >> i) & 1) m_pos[i] = longint'(m_start[i]) << 19;
                    m_on = (~d) & 'hFF;
                end
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        bit         pw;
        int         pa;
        bit [7:0]   pd;
        string      ptag;
        ptag = eng_upd_valid ? "R9" : "R3";
        #1;
        mem_rdata = phys_mem.exists(int'(mem_addr)) ? phys_mem[int'(mem_addr)] : 8'h00;
        if (!rst && bus_sel && bus_addr[12]) begin
            // R6 window address and strobe
            chk(int'(mem_addr) == m_bank * 4096 + int'(bus_addr[11:0]), "R6", mem_addr,
                m_bank * 4096 + int'(bus_addr[11:0]));
            chk(mem_we == bus_we, "R6", mem_we, bus_we);
        end
        pw = mem_we; pa = int'(mem_addr); pd = mem_wdata;
        @(posedge clk);
        model_step();
        if (pw) phys_mem[pa] = pd;
        #2;
        chk(int'(bus_rdata) == m_rdata, m_rtag, bus_rdata, m_rdata);
        chk(int'(chan_on) == m_on, "R5", chan_on, m_on);
        chk(int'(glob_en) == m_en, "R4", glob_en, m_en);
        chk(int'(eng_env) == m_env[eng_ch] && int'(eng_pan) == m_pan[eng_ch], "R2",
            {eng_env, eng_pan}, (m_env[eng_ch] << 8) | m_pan[eng_ch]);
        chk(int'(eng_step) == m_step[eng_ch] && int'(eng_loop) == m_loop[eng_ch], "R2",
            {eng_step, eng_loop}, (longint'(m_step[eng_ch]) << 16) | m_loop[eng_ch]);
        chk(longint'(eng_pos) == m_pos[eng_ch], ptag, eng_pos, m_pos[eng_ch]);
    endtask

    // R10 sweep of the engine view across all voices
    task automatic view_all(input string tag);
        for (int c = 0; c < 8; c++) begin
            eng_ch = 3'(c);
            #1;
            chk(int'(eng_env) == m_env[c], tag, eng_env, m_env[c]);
            chk(int'(eng_pan) == m_pan[c], tag, eng_pan, m_pan[c]);
            chk(int'(eng_step) == m_step[c], tag, eng_step, m_step[c]);
            chk(int'(eng_loop) == m_loop[c], tag, eng_loop, m_loop[c]);
            chk(int'(eng_start) == m_start[c], tag, eng_start, m_start[c]);
            chk(longint'(eng_pos) == m_pos[c], tag, eng_pos, m_pos[c]);
        end
        eng_ch = '0;
    endtask

    task automatic wr(input int a, input int d);
        bus_sel = 1; bus_we = 1; bus_addr = 13'(a); bus_wdata = 8'(d);
        tick();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_sel = 1; bus_we = 0; bus_addr = 13'(a); nxt_tag = tag;
        tick();
        bus_sel = 0;
    endtask

    task automatic eng(input int ch, input longint p);
        eng_upd_valid = 1; eng_upd_ch = 3'(ch); eng_upd_pos = 27'(p & PMASK);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        tick(); tick();
        rst = 0;
        tick();
        view_all("R1");
        chk(bus_rdata == 8'h00, "R1", bus_rdata, 0);

        // R4 select voice 3 with run flag, R2 fields, R3 start while off
        wr('h07, 'hC3);
        wr('h00, 'h40); wr('h01, 'h5A); wr('h02, 'h34); wr('h03, 'h12);
        wr('h04, 'h78); wr('h05, 'h06); wr('h06, 'h21);
        view_all("R2");
        // R4 voice 5 without run flag; voice 3 must keep its fields
        wr('h07, 'h45);
        wr('h00, 'h11); wr('h03, 'hEE); wr('h06, 'h9C);
        view_all("R10");
        // R7 pointer readback, both halves
        rd('h16, "R7"); rd('h17, "R7"); rd('h1A, "R7"); rd('h1B, "R7");

        // R5 gate: voice 3 on, others off and rewound
        eng_ch = 3'd5;
        eng(5, 'h1234567); tick(); eng_upd_valid = 0;
        wr('h08, 'hF7);
        view_all("R5");
        eng(3, 'h5ABCDEF); tick(); eng_upd_valid = 0;
        rd('h16, "R7"); rd('h17, "R7");
        // R3 start write on a running voice leaves the position
        wr('h07, 'h43);
        wr('h06, 'h77);
        view_all("R3");
        // R9 engine vs gate reload, same cycle
        eng(0, 'h7FFFFFF); wr('h08, 'h01); eng_upd_valid = 0;
        view_all("R9");
        eng(3, 'h0000800); wr('h08, 'h01); eng_upd_valid = 0;
        view_all("R9");
        // R9 engine vs start reload on an off voice
        wr('h07, 'h40);
        eng(0, 'h3333333); wr('h06, 'h55); eng_upd_valid = 0;
        view_all("R9");

        // R6 window across pages
        wr('h07, 'h02); wr('h1005, 'hAB);
        wr('h07, 'h07); wr('h1005, 'hCD); wr('h1FFF, 'h5E);
        wr('h07, 'h0F); wr('h1000, 'h99); wr('h1FFF, 'h42);
        rd('h1FFF, "R6"); rd('h1000, "R6");
        wr('h07, 'h02); rd('h1005, "R6");
        wr('h07, 'h86); // voice select would be 6 but bit 6 clear: page 6
        rd('h1005, "R6");
        wr('h07, 'hC7); // R4 voice select keeps page 6... then go to page 7
        rd('h1005, "R4");
        wr('h07, 'h07); rd('h1005, "R6"); rd('h1FFF, "R6");

        // R8 empty reads and ignored writes
        rd('h00, "R8"); rd('h08, "R8"); rd('h0F, "R8"); rd('h20, "R8"); rd('h0FFF, "R8");
        wr('h09, 'h00); wr('h0A, 'hFF); wr('h0F, 'h12); wr('h18, 'h34); wr('h0FFF, 'h56);
        view_all("R8");
        tick(); tick();
        chk(bus_rdata == 8'hFF, "R8", bus_rdata, 8'hFF);

        // R7 all voices' pointers
        for (int c = 0; c < 8; c++) begin
            eng(c, (longint'(c) * 'h0912345) ^ 'h2A5A5A5); tick(); eng_upd_valid = 0;
        end
        for (int a = 'h10; a < 'h20; a++) rd(a, "R7");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule